// File: doc/BRIEF.md
# UART FIFO Threshold Interrupt Controller

This block produces the interrupt requests that tell software when to refill the transmit FIFO and when to drain the receive FIFO of a UART with 64-entry queues. It watches the fill levels of both FIFOs and a flag that says whether the transmit shift register is still sending. From these and a set of control fields it derives a transmit-holding (THR) interrupt, a receive-trigger interrupt and the line-status bit that reports an empty transmit FIFO.

The THR interrupt has two modes. In threshold mode it fires as soon as the transmit FIFO occupancy drops below a programmed 6-bit threshold, or when the whole transmit path is idle. In drain mode it fires only when both the FIFO and the shift register are empty. The receive trigger level comes either from a coarse 2-bit code or from a fine 6-bit value formed from two fields. In the fine case the value can be set to any level from 1 to 63 characters.

The THR request is sticky. A read of the interrupt-identification register clears it, but only if the condition has gone away by then. Each request has its own enable, and the unmasked raw state is also brought out. All control fields are registered before use. The FIFO storage, the baud generator, the serializer and the bus interface are outside the block.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, `thr_irq`, `rx_irq`, `thr_raw`, `rx_raw` and `lsr_tx_empty` are all 0.
- R2: `lsr_tx_empty` is 1 one clock after `tx_level` is 0 and is 0 one clock after it is nonzero. The state of `tx_shift_busy` does not affect it.
- R3: With `tx_drain_mode` = 0, `thr_raw` becomes 1 when `tx_level < tx_thresh`, or when `tx_level` is 0 and `tx_shift_busy` is 0.
- R4: With `tx_drain_mode` = 1, `thr_raw` becomes 1 only when `tx_level` is 0 and `tx_shift_busy` is 0. A FIFO level below `tx_thresh` does not set it.
- R5: Once `thr_raw` is set, it stays 1 until a clock in which `iir_rd` is 1 and the THR condition of R3/R4 is false. It then drops on that clock. A read while the condition holds leaves it at 1.
- R6: With `rx_fine_gran` = 0, the receive trigger level is 8, 16, 56 or 60 characters for `rx_trig_code` = 0, 1, 2 or 3.
- R7: With `rx_fine_gran` = 1, the receive trigger level is the 6-bit value {`rx_trig_hi`[3:0], `rx_trig_code`[1:0]}, with `rx_trig_hi` in the upper bits.
- R8: With `rx_fine_gran` = 1 and an all-zero fine value, the receive trigger level is 1 character.
- R9: `rx_raw` is a level signal. One clock after `rx_level` is at or above the active trigger level it is 1, and one clock after `rx_level` is below that level it is 0.
- R10: `thr_irq` equals `thr_raw` masked by `thr_en`, and `rx_irq` equals `rx_raw` masked by `rx_en`. A disabled request still shows on its raw output.
- R11: A change on a control input (`tx_drain_mode`, `rx_fine_gran`, `rx_trig_code`, `rx_trig_hi`, `tx_thresh`, `thr_en`, `rx_en`) reaches the outputs two clocks later. A change on `tx_level`, `tx_shift_busy`, `rx_level` or `iir_rd` reaches them one clock later. Every output is driven by a flop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_level | input | LVL_W (7) | Transmit FIFO occupancy, 0 to 64 |
| tx_shift_busy | input | 1 | Transmit shift register still holds data |
| rx_level | input | LVL_W (7) | Receive FIFO occupancy, 0 to 64 |
| tx_drain_mode | input | 1 | THR mode select: 1 = drain mode, 0 = threshold mode |
| rx_fine_gran | input | 1 | Receive trigger encoding: 1 = fine, 0 = coarse table |
| rx_trig_code | input | 2 | Coarse code, or low bits of the fine level |
| rx_trig_hi | input | 4 | High bits of the fine receive level |
| tx_thresh | input | 6 | Transmit threshold used in threshold mode |
| thr_en | input | 1 | THR interrupt enable |
| rx_en | input | 1 | Receive trigger interrupt enable |
| iir_rd | input | 1 | One-clock pulse for a read of the interrupt-identification register |
| thr_irq | output | 1 | Masked THR interrupt |
| rx_irq | output | 1 | Masked receive trigger interrupt |
| thr_raw | output | 1 | Unmasked THR pending state |
| rx_raw | output | 1 | Unmasked receive trigger state |
| lsr_tx_empty | output | 1 | Line-status bit: transmit FIFO holds no data |

## Verification
The assertions assume that `tx_level` and `rx_level` stay within 0 to 64 and that each stimulus value is held across the clock that samples it. The bench changes every input on the falling edge and never drives a level above 64, so both assumptions hold. The rules on the receive trigger rely on every legal trigger level lying between 1 and 63. An empty receive FIFO must therefore never raise the request, and a full one always must. Before it checks a sticky-clear case, the bench holds the THR condition false through the read pulse.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int TRIG_W = 6;
  localparam int CODE_W = 2;
  localparam int HI_W   = TRIG_W - CODE_W;

  typedef struct packed {
    logic              drain_mode;
    logic              rx_fine;
    logic [CODE_W-1:0] rx_code;
    logic [HI_W-1:0]   rx_hi;
    logic [TRIG_W-1:0] tx_thresh;
    logic              thr_en;
    logic              rx_en;
  } irq_cfg_t;

  // coarse receive trigger table, indexed by the 2-bit code
  function automatic logic [TRIG_W-1:0] coarse_level(input logic [CODE_W-1:0] code);
    logic [TRIG_W-1:0] lvl;
    case (code)
      2'd0:    lvl = TRIG_W'(8);
      2'd1:    lvl = TRIG_W'(16);
      2'd2:    lvl = TRIG_W'(56);
      default: lvl = TRIG_W'(60);
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import uart_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_cfg_t cfg_d,
  output irq_cfg_t cfg_q
);
  logic cfg_ce;

  // load only when a field differs, so the flops hold otherwise
  always_comb begin
    cfg_ce = (cfg_d != cfg_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_ce) cfg_q <= cfg_d;
  end
endmodule

// File: rtl/rx_trig_gen.sv
module rx_trig_gen
  import uart_irq_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  irq_cfg_t         cfg,
  output logic             raw_q,
  output logic             irq_q
);
  logic [TRIG_W-1:0] fine_val;
  logic [TRIG_W-1:0] trig_lvl;
  logic              raw_d;
  logic              irq_d;
  logic              out_ce;

  always_comb begin
    fine_val = {cfg.rx_hi, cfg.rx_code};
    if (cfg.rx_fine) begin
      // an all-zero fine value is illegal; clamp it to one character
      trig_lvl = (fine_val == '0) ? TRIG_W'(1) : fine_val;
    end else begin
      trig_lvl = coarse_level(cfg.rx_code);
    end
    raw_d  = (rx_level >= LVL_W'(trig_lvl));
    irq_d  = raw_d & cfg.rx_en;
    out_ce = (raw_d != raw_q) || (irq_d != irq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
      irq_q <= 1'b0;
    end else if (out_ce) begin
      raw_q <= raw_d;
      irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/thr_irq_gen.sv
module thr_irq_gen
  import uart_irq_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             tx_shift_busy,
  input  logic             iir_rd,
  input  irq_cfg_t         cfg,
  output logic             pend_q,
  output logic             irq_q,
  output logic             fifo_empty_q
);
  logic path_empty;
  logic below_thr;
  logic cond;
  logic pend_d;
  logic irq_d;
  logic empty_d;
  logic out_ce;

  always_comb begin
    path_empty = (tx_level == '0) && !tx_shift_busy;
    below_thr  = (tx_level < LVL_W'(cfg.tx_thresh));
    cond       = cfg.drain_mode ? path_empty : (below_thr || path_empty);
    // sticky: set by the condition, cleared only by a read once it is gone
    pend_d     = cond || (pend_q && !iir_rd);
    irq_d      = pend_d && cfg.thr_en;
    empty_d    = (tx_level == '0);
    out_ce     = (pend_d != pend_q) || (irq_d != irq_q) || (empty_d != fifo_empty_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q       <= 1'b0;
      irq_q        <= 1'b0;
      fifo_empty_q <= 1'b0;
    end else if (out_ce) begin
      pend_q       <= pend_d;
      irq_q        <= irq_d;
      fifo_empty_q <= empty_d;
    end
  end
endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             tx_shift_busy,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             tx_drain_mode,
  input  logic             rx_fine_gran,
  input  logic [1:0]       rx_trig_code,
  input  logic [3:0]       rx_trig_hi,
  input  logic [5:0]       tx_thresh,
  input  logic             thr_en,
  input  logic             rx_en,
  input  logic             iir_rd,
  output logic             thr_irq,
  output logic             rx_irq,
  output logic             thr_raw,
  output logic             rx_raw,
  output logic             lsr_tx_empty
);
  logic     rst_int_n;
  irq_cfg_t cfg_d;
  irq_cfg_t cfg_q;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  always_comb begin
    cfg_d.drain_mode = tx_drain_mode;
    cfg_d.rx_fine    = rx_fine_gran;
    cfg_d.rx_code    = rx_trig_code;
    cfg_d.rx_hi      = rx_trig_hi;
    cfg_d.tx_thresh  = tx_thresh;
    cfg_d.thr_en     = thr_en;
    cfg_d.rx_en      = rx_en;
  end

  irq_cfg_regs u_cfg (
    .clk   (clk),
    .rst_n (rst_int_n),
    .cfg_d (cfg_d),
    .cfg_q (cfg_q)
  );

  thr_irq_gen #(.LVL_W(LVL_W)) u_thr (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .tx_level      (tx_level),
    .tx_shift_busy (tx_shift_busy),
    .iir_rd        (iir_rd),
    .cfg           (cfg_q),
    .pend_q        (thr_raw),
    .irq_q         (thr_irq),
    .fifo_empty_q  (lsr_tx_empty)
  );

  rx_trig_gen #(.LVL_W(LVL_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rx_level (rx_level),
    .cfg      (cfg_q),
    .raw_q    (rx_raw),
    .irq_q    (rx_irq)
  );
endmodule

// File: rtl/fifo_irq_ctrl_chk.sv
module fifo_irq_ctrl_chk #(
  parameter int LVL_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] tx_level,
  input logic             tx_shift_busy,
  input logic [LVL_W-1:0] rx_level,
  input logic             tx_drain_mode,
  input logic             thr_en,
  input logic             rx_en,
  input logic             iir_rd,
  input logic             thr_irq,
  input logic             rx_irq,
  input logic             thr_raw,
  input logic             rx_raw,
  input logic             lsr_tx_empty
);
  logic [2:0] age;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end
  assign warm = (age >= 3'd5);

  // R2
  lsr_tracks_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (lsr_tx_empty == $past(tx_level == '0)));

  // R4
  drain_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $rose(thr_raw) && $past(tx_drain_mode, 2)) |->
      $past((tx_level == '0) && !tx_shift_busy));

  // R5
  thr_clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $fell(thr_raw)) |-> $past(iir_rd));

  // R9
  rx_empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(rx_level == '0)) |-> !rx_raw);

  // R9
  rx_full_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(rx_level == LVL_W'(64))) |-> rx_raw);

  // R10
  thr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && thr_irq) |-> (thr_raw && $past(thr_en, 2)));

  // R10
  rx_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && rx_irq) |-> (rx_raw && $past(rx_en, 2)));
endmodule

bind fifo_irq_ctrl fifo_irq_ctrl_chk #(.LVL_W(LVL_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tx_level      (tx_level),
  .tx_shift_busy (tx_shift_busy),
  .rx_level      (rx_level),
  .tx_drain_mode (tx_drain_mode),
  .thr_en        (thr_en),
  .rx_en         (rx_en),
  .iir_rd        (iir_rd),
  .thr_irq       (thr_irq),
  .rx_irq        (rx_irq),
  .thr_raw       (thr_raw),
  .rx_raw        (rx_raw),
  .lsr_tx_empty  (lsr_tx_empty)
);

// File: tb/tb_fifo_irq_ctrl.sv
module tb_fifo_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LVL_W      = 7;

  logic             clk;
  logic             rst_n;
  logic [LVL_W-1:0] tx_level;
  logic             tx_shift_busy;
  logic [LVL_W-1:0] rx_level;
  logic             tx_drain_mode;
  logic             rx_fine_gran;
  logic [1:0]       rx_trig_code;
  logic [3:0]       rx_trig_hi;
  logic [5:0]       tx_thresh;
  logic             thr_en;
  logic             rx_en;
  logic             iir_rd;
  logic             thr_irq;
  logic             rx_irq;
  logic             thr_raw;
  logic             rx_raw;
  logic             lsr_tx_empty;

  int  n_run;
  int  n_fail;
  bit  done;

  fifo_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .tx_shift_busy(tx_shift_busy),
    .rx_level(rx_level), .tx_drain_mode(tx_drain_mode), .rx_fine_gran(rx_fine_gran),
    .rx_trig_code(rx_trig_code), .rx_trig_hi(rx_trig_hi), .tx_thresh(tx_thresh),
    .thr_en(thr_en), .rx_en(rx_en), .iir_rd(iir_rd), .thr_irq(thr_irq),
    .rx_irq(rx_irq), .thr_raw(thr_raw), .rx_raw(rx_raw), .lsr_tx_empty(lsr_tx_empty)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic act, input logic exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic read_iir();
    iir_rd = 1'b1;
    idle(1);
    iir_rd = 1'b0;
    idle(1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tx_level = '0; tx_shift_busy = 1'b0; rx_level = '0;
    tx_drain_mode = 1'b0; rx_fine_gran = 1'b0; rx_trig_code = 2'd0; rx_trig_hi = 4'd0;
    tx_thresh = 6'd0; thr_en = 1'b1; rx_en = 1'b1; iir_rd = 1'b0;
    idle(4);
    chk(thr_irq | rx_irq | thr_raw | rx_raw | lsr_tx_empty, 1'b0, "R1 outputs low in reset");
    rst_n = 1'b1;
    idle(5);
  endtask

  task automatic t_lsr();
    tx_level = '0; tx_shift_busy = 1'b1;
    idle(3);
    chk(lsr_tx_empty, 1'b1, "R2 empty FIFO with busy shifter");
    tx_level = 7'd5;
    idle(1);
    chk(lsr_tx_empty, 1'b0, "R2 nonempty FIFO after one clock");
  endtask

  task automatic t_normal_thr();
    tx_drain_mode = 1'b0; tx_thresh = 6'd16; thr_en = 1'b1;
    tx_level = 7'd40; tx_shift_busy = 1'b1;
    idle(3);
    read_iir();
    chk(thr_raw, 1'b0, "R5 cleared by read with condition false");
    tx_level = 7'd15;
    idle(1);
    chk(thr_raw, 1'b1, "R3 level below threshold raw");
    chk(thr_irq, 1'b1, "R3 level below threshold irq");
    tx_level = 7'd16;
    idle(3);
    chk(thr_raw, 1'b1, "R5 sticky after condition gone");
    read_iir();
    chk(thr_raw, 1'b0, "R5 read clears");
    tx_thresh = 6'd0; tx_level = '0; tx_shift_busy = 1'b0;
    idle(3);
    chk(thr_raw, 1'b1, "R3 path empty with zero threshold");
  endtask

  task automatic t_drain();
    tx_drain_mode = 1'b1; tx_thresh = 6'd16;
    tx_level = 7'd40; tx_shift_busy = 1'b1;
    idle(3);
    read_iir();
    chk(thr_raw, 1'b0, "R4 cleared before drain test");
    tx_level = 7'd2;
    idle(3);
    chk(thr_raw, 1'b0, "R4 below threshold ignored in drain mode");
    tx_level = '0;
    idle(3);
    chk(thr_raw, 1'b0, "R4 shifter busy blocks");
    tx_shift_busy = 1'b0;
    idle(1);
    chk(thr_raw, 1'b1, "R4 fully drained fires");
    read_iir();
    chk(thr_raw, 1'b1, "R5 read while condition holds keeps it");
  endtask

  task automatic rx_edge(input logic [5:0] lvl, input string tag);
    rx_level = LVL_W'(lvl) - 7'd1;
    idle(3);
    chk(rx_raw, 1'b0, {tag, " one below level"});
    rx_level = LVL_W'(lvl);
    idle(1);
    chk(rx_raw, 1'b1, {tag, " at level"});
  endtask

  task automatic t_coarse();
    rx_fine_gran = 1'b0; rx_en = 1'b1; rx_trig_hi = 4'd9;
    rx_trig_code = 2'd0; rx_edge(6'd8,  "R6 code0");
    rx_trig_code = 2'd1; rx_edge(6'd16, "R6 code1");
    rx_trig_code = 2'd2; rx_edge(6'd56, "R6 code2");
    rx_trig_code = 2'd3; rx_edge(6'd60, "R6 code3");
    rx_level = 7'd12;
    idle(1);
    chk(rx_raw, 1'b0, "R9 deasserts below level");
  endtask

  task automatic t_fine();
    rx_fine_gran = 1'b1;
    rx_trig_hi = 4'd5;  rx_trig_code = 2'd2; rx_edge(6'd22, "R7 level 22");
    rx_trig_hi = 4'd15; rx_trig_code = 2'd3; rx_edge(6'd63, "R7 level 63");
    rx_trig_hi = 4'd0;  rx_trig_code = 2'd0; rx_edge(6'd1,  "R8 zero means 1");
  endtask

  task automatic t_enable();
    rx_fine_gran = 1'b0; rx_trig_code = 2'd0; rx_en = 1'b0; rx_level = 7'd64;
    idle(3);
    chk(rx_raw, 1'b1, "R10 rx raw while disabled");
    chk(rx_irq, 1'b0, "R10 rx irq masked");
    thr_en = 1'b0; tx_level = '0; tx_shift_busy = 1'b0;
    idle(3);
    chk(thr_raw, 1'b1, "R10 thr raw while disabled");
    chk(thr_irq, 1'b0, "R10 thr irq masked");
    rx_en = 1'b1; thr_en = 1'b1;
    idle(3);
    chk(rx_irq & thr_irq, 1'b1, "R10 irqs after enable");
  endtask

  task automatic t_latency();
    rx_fine_gran = 1'b0; rx_trig_code = 2'd0; rx_level = 7'd10;
    idle(3);
    chk(rx_raw, 1'b1, "R11 setup level 8");
    rx_trig_code = 2'd3;
    idle(1);
    chk(rx_raw, 1'b1, "R11 control not yet applied");
    idle(1);
    chk(rx_raw, 1'b0, "R11 control applied after two clocks");
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    t_reset();
    t_lsr();
    t_normal_thr();
    t_drain();
    t_coarse();
    t_fine();
    t_enable();
    t_latency();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule